// File: doc/BRIEF.md
# Frame-Delimiter Timestamp Capture Unit

This block stamps Ethernet frames with hardware time as they cross between the MAC and the PHY. One byte lane carries received traffic and one carries transmitted traffic. Both lanes use the same framing: a data-valid strobe and one byte per clock. A raw time counter starts at zero after reset and then runs freely. Nothing can load or trim it. When the start-of-frame delimiter byte passes on either lane, the block latches the whole counter and raises a one-cycle event on that lane.

After the delimiter the block checks the frame header at fixed offsets. It only keeps frames that are untagged IPv4/UDP and carry the precision-time event port. For such a frame it queues the latched time with a direction bit. Every other frame loses its timestamp. Software drains the queue through a simple read strobe. Converting raw time into disciplined time is left to software.

Top module: `ftc_capture_unit`

## Requirements
- R1: The raw time `{high, low}` is 0 on the first clock after reset and then grows by exactly 1 on every clock. A stored timestamp equals the number of clock edges since reset release, counted at the cycle the delimiter byte is presented.
- R2: A delimiter is byte 0xD5 with its lane's valid high. It must be either the first valid byte of a burst or follow only 0x55 preamble bytes. On that clock edge the full raw time is latched for that lane.
- R3: `ts_event[d]` is high for exactly the one cycle after the edge that accepted the delimiter on lane d. Bit 0 is receive and bit 1 is transmit.
- R4: Byte offsets are counted from 0 at the first byte after the delimiter. A frame qualifies only if all of these hold: offset 12 = 0x08, offset 13 = 0x00, offset 14 = 0x45, offset 23 = 0x11, offset 36 = 0x01, offset 37 = 0x3F. A qualifying frame adds one queue entry.
- R5: A frame is dropped and adds no entry in two cases: any checked byte differs, or the valid strobe falls before offset 37.
- R6: Each entry holds a direction bit (0 receive, 1 transmit) and the latched raw time. Entries leave in arrival order. If both lanes qualify on the same cycle, the receive entry is queued first.
- R7: The queue holds DEPTH entries. If a qualified timestamp arrives while the queue is full, it is discarded and `overflow` goes high. `overflow` then stays high until reset.
- R8: Right after reset: `fifo_empty` = 1, `overflow` = 0, `ts_event` = 0, `rd_valid` = 0.
- R9: Raising `rd_en` while the queue holds entries makes `rd_valid` high on the next cycle, with the oldest entry on `rd_dir`/`rd_time`. Raising `rd_en` on an empty queue does nothing: `rd_valid` stays 0 and no entry is lost.
- R10: The low counter wraps to zero on the same edge as the high word increments. A delimiter accepted on the cycle where the low part reads zero is stored with the already-incremented high word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timebase and byte clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_dv | input | 1 | Receive lane byte valid |
| rx_byte | input | 8 | Receive lane byte |
| tx_dv | input | 1 | Transmit lane byte valid |
| tx_byte | input | 8 | Transmit lane byte |
| ts_event | output | 2 | Delimiter capture pulse per lane (bit 0 receive) |
| rd_en | input | 1 | Pop request for the oldest queued timestamp |
| rd_valid | output | 1 | Read data valid, one cycle after an accepted pop |
| rd_dir | output | 1 | Direction of the popped entry (1 = transmit) |
| rd_time | output | LO_W+HI_W | Raw time of the popped entry |
| fifo_empty | output | 1 | Queue holds no entries |
| overflow | output | 1 | Sticky flag: a qualified timestamp was lost |

## Verification
Some properties are checked by assertions on every cycle. The counter must advance by one, and a low-part wrap must carry into the high word on that same edge. Capture events must be single-cycle pulses, and the overflow flag, once set, must stay set and have been caused by a push into a full queue. Read data may only appear one cycle after an accepted pop, and the reset state must be clean.

Other behaviour needs the bench's scenarios to expose it. Header qualification versus rejection needs whole frames. So do exact timestamp values at and around the wrap, receive-before-transmit ordering when both lanes qualify together, and loss of the ninth entry when the queue is full.

// File: rtl/ftc_pkg.sv
package ftc_pkg;

  localparam int NDIR   = 2;
  localparam int DIR_RX = 0;
  localparam int DIR_TX = 1;

  localparam logic [7:0] BYTE_PREAMBLE = 8'h55;
  localparam logic [7:0] BYTE_DELIM    = 8'hD5;

  // last header offset inspected for qualification
  localparam int LAST_OFF = 37;
  localparam int IDX_W    = $clog2(LAST_OFF + 1);

  typedef enum logic [1:0] {
    PS_IDLE,
    PS_PREAMBLE,
    PS_HEADER,
    PS_SKIP
  } parse_st_t;

  // offsets of an untagged IPv4/UDP frame that must match
  function automatic logic hdr_checked(input logic [IDX_W-1:0] idx);
    case (idx)
      6'd12, 6'd13, 6'd14, 6'd23, 6'd36, 6'd37: hdr_checked = 1'b1;
      default:                                   hdr_checked = 1'b0;
    endcase
  endfunction

  function automatic logic [7:0] hdr_expect(input logic [IDX_W-1:0] idx);
    case (idx)
      6'd12:   hdr_expect = 8'h08;  // ethertype high
      6'd13:   hdr_expect = 8'h00;  // ethertype low
      6'd14:   hdr_expect = 8'h45;  // version 4, 20-byte header
      6'd23:   hdr_expect = 8'h11;  // protocol UDP
      6'd36:   hdr_expect = 8'h01;  // destination port high
      6'd37:   hdr_expect = 8'h3F;  // destination port low (319)
      default: hdr_expect = 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/ftc_timebase.sv
module ftc_timebase #(
  parameter int LO_W = 32,
  parameter int HI_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  output logic [LO_W-1:0] raw_lo,
  output logic [HI_W-1:0] raw_hi
);

  // free-running, never loaded; carry lands on the wrap edge
  always_ff @(posedge clk) begin
    if (rst) begin
      raw_lo <= '0;
      raw_hi <= '0;
    end else begin
      raw_lo <= raw_lo + 1'b1;
      if (&raw_lo) raw_hi <= raw_hi + 1'b1;
    end
  end

endmodule

// File: rtl/ftc_frame_qual.sv
module ftc_frame_qual
  import ftc_pkg::*;
#(
  parameter int TS_W = 48
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            dv,
  input  logic [7:0]      data,
  input  logic [TS_W-1:0] now,
  output logic            cap_evt,
  output logic            qual,
  output logic [TS_W-1:0] ts
);

  parse_st_t        st;
  logic [IDX_W-1:0] idx;
  logic             ok;
  logic             delim_hit;

  assign delim_hit = dv && (data == BYTE_DELIM) &&
                     ((st == PS_IDLE) || (st == PS_PREAMBLE));

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= PS_IDLE;
      idx     <= '0;
      ok      <= 1'b0;
      cap_evt <= 1'b0;
      qual    <= 1'b0;
      ts      <= '0;
    end else begin
      cap_evt <= 1'b0;
      qual    <= 1'b0;
      if (delim_hit) begin
        ts      <= now;
        cap_evt <= 1'b1;
        idx     <= '0;
        ok      <= 1'b1;
        st      <= PS_HEADER;
      end else begin
        case (st)
          PS_IDLE: begin
            if (dv) st <= (data == BYTE_PREAMBLE) ? PS_PREAMBLE : PS_SKIP;
          end
          PS_PREAMBLE: begin
            if (!dv)                        st <= PS_IDLE;
            else if (data != BYTE_PREAMBLE) st <= PS_SKIP;
          end
          PS_HEADER: begin
            if (!dv) begin
              st <= PS_IDLE;
            end else begin
              if (hdr_checked(idx) && (data != hdr_expect(idx))) ok <= 1'b0;
              if (idx == IDX_W'(LAST_OFF)) begin
                qual <= ok && (data == hdr_expect(idx));
                st   <= PS_SKIP;
              end else begin
                idx <= idx + 1'b1;
              end
            end
          end
          default: begin
            if (!dv) st <= PS_IDLE;
          end
        endcase
      end
    end
  end

endmodule

// File: rtl/ftc_ts_fifo.sv
module ftc_ts_fifo #(
  parameter int W     = 49,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] pop_data,
  output logic         pop_vld,
  output logic         empty,
  output logic         full
);

  localparam int AW = $clog2(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [AW:0]   count;
  logic          do_push, do_pop;

  assign empty   = (count == '0);
  assign full    = (count == (AW+1)'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;

  // storage without reset so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (do_pop) pop_data <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count   <= '0;
      pop_vld <= 1'b0;
    end else begin
      pop_vld <= do_pop;
      if (do_push) wr_ptr <= wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/ftc_capture_unit.sv
module ftc_capture_unit
  import ftc_pkg::*;
#(
  parameter int LO_W  = 32,
  parameter int HI_W  = 16,
  parameter int DEPTH = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rx_dv,
  input  logic [7:0]           rx_byte,
  input  logic                 tx_dv,
  input  logic [7:0]           tx_byte,
  output logic [1:0]           ts_event,
  input  logic                 rd_en,
  output logic                 rd_valid,
  output logic                 rd_dir,
  output logic [LO_W+HI_W-1:0] rd_time,
  output logic                 fifo_empty,
  output logic                 overflow
);

  localparam int TS_W  = LO_W + HI_W;
  localparam int ENT_W = TS_W + 1;

  logic [LO_W-1:0]  raw_lo;
  logic [HI_W-1:0]  raw_hi;
  logic [TS_W-1:0]  raw_now;

  logic [NDIR-1:0]  dv_v;
  logic [7:0]       byte_v [NDIR];
  logic [NDIR-1:0]  evt_v;
  logic [NDIR-1:0]  qual_v;
  logic [TS_W-1:0]  cap_ts [NDIR];

  logic             pend_v  [NDIR];
  logic [TS_W-1:0]  pend_ts [NDIR];
  logic [NDIR-1:0]  gnt;
  logic             push_req;
  logic             sel_dir;
  logic [TS_W-1:0]  sel_ts;
  logic             fifo_full;
  logic [ENT_W-1:0] pop_data;

  ftc_timebase #(.LO_W(LO_W), .HI_W(HI_W)) u_timebase (
    .clk    (clk),
    .rst    (rst),
    .raw_lo (raw_lo),
    .raw_hi (raw_hi)
  );

  assign raw_now           = {raw_hi, raw_lo};
  assign dv_v              = {tx_dv, rx_dv};
  assign byte_v[DIR_RX]    = rx_byte;
  assign byte_v[DIR_TX]    = tx_byte;
  assign ts_event          = evt_v;

  for (genvar g = 0; g < NDIR; g++) begin : g_lane
    ftc_frame_qual #(.TS_W(TS_W)) u_qual (
      .clk     (clk),
      .rst     (rst),
      .dv      (dv_v[g]),
      .data    (byte_v[g]),
      .now     (raw_now),
      .cap_evt (evt_v[g]),
      .qual    (qual_v[g]),
      .ts      (cap_ts[g])
    );
  end

  // one qualified timestamp per lane waits here until granted
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NDIR; i++) begin
        pend_v[i]  <= 1'b0;
        pend_ts[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NDIR; i++) begin
        if (qual_v[i]) begin
          pend_v[i]  <= 1'b1;
          pend_ts[i] <= cap_ts[i];
        end else if (gnt[i]) begin
          pend_v[i]  <= 1'b0;
        end
      end
    end
  end

  // fixed priority: receive lane first
  always_comb begin
    gnt      = '0;
    push_req = 1'b0;
    sel_dir  = 1'b0;
    sel_ts   = '0;
    for (int i = 0; i < NDIR; i++) begin
      if (pend_v[i] && !push_req) begin
        gnt[i]   = 1'b1;
        push_req = 1'b1;
        sel_dir  = (i == DIR_TX);
        sel_ts   = pend_ts[i];
      end
    end
  end

  ftc_ts_fifo #(.W(ENT_W), .DEPTH(DEPTH)) u_fifo (
    .clk       (clk),
    .rst       (rst),
    .push      (push_req),
    .push_data ({sel_dir, sel_ts}),
    .pop       (rd_en),
    .pop_data  (pop_data),
    .pop_vld   (rd_valid),
    .empty     (fifo_empty),
    .full      (fifo_full)
  );

  assign rd_dir  = pop_data[TS_W];
  assign rd_time = pop_data[TS_W-1:0];

  always_ff @(posedge clk) begin
    if (rst)                        overflow <= 1'b0;
    else if (push_req && fifo_full) overflow <= 1'b1;
  end

endmodule

// File: rtl/ftc_capture_chk.sv
module ftc_capture_chk #(
  parameter int LO_W = 32,
  parameter int HI_W = 16
) (
  input logic            clk,
  input logic            rst,
  input logic [LO_W-1:0] raw_lo,
  input logic [HI_W-1:0] raw_hi,
  input logic [1:0]      ts_event,
  input logic            rd_en,
  input logic            rd_valid,
  input logic            fifo_empty,
  input logic            fifo_full,
  input logic            push_req,
  input logic            overflow
);

  localparam int TS_W = LO_W + HI_W;

  assert_count_step_R1: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ({raw_hi, raw_lo} == $past({raw_hi, raw_lo}) + TS_W'(1)));

  assert_wrap_carry_R10: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(&raw_lo)) |-> (raw_lo == '0 && raw_hi == $past(raw_hi) + HI_W'(1)));

  assert_rx_event_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    ts_event[0] |=> !ts_event[0]);

  assert_tx_event_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    ts_event[1] |=> !ts_event[1]);

  assert_overflow_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);

  assert_overflow_cause_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(overflow) |-> $past(push_req && fifo_full));

  assert_read_after_pop_R9: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(rd_en && !fifo_empty));

  assert_reset_state_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (fifo_empty && !overflow && ts_event == 2'b00 && !rd_valid));

endmodule

bind ftc_capture_unit ftc_capture_chk #(.LO_W(LO_W), .HI_W(HI_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .raw_lo     (raw_lo),
  .raw_hi     (raw_hi),
  .ts_event   (ts_event),
  .rd_en      (rd_en),
  .rd_valid   (rd_valid),
  .fifo_empty (fifo_empty),
  .fifo_full  (fifo_full),
  .push_req   (push_req),
  .overflow   (overflow)
);

// File: tb/test_ftc_capture_unit.sv
module test_ftc_capture_unit;

  localparam int LO_W  = 10;
  localparam int HI_W  = 6;
  localparam int DEPTH = 8;
  localparam int TS_W  = LO_W + HI_W;

  // frame kinds
  localparam int K_PTP   = 0;
  localparam int K_PORT  = 1;
  localparam int K_ETYPE = 2;
  localparam int K_PROTO = 3;
  localparam int K_SHORT = 4;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            rx_dv = 1'b0, tx_dv = 1'b0;
  logic [7:0]      rx_byte = 8'h00, tx_byte = 8'h00;
  logic [1:0]      ts_event;
  logic            rd_en = 1'b0;
  logic            rd_valid, rd_dir, fifo_empty, overflow;
  logic [TS_W-1:0] rd_time;

  int tests = 0;
  int fails = 0;
  logic [TS_W-1:0] edges;

  always #10 clk = ~clk;

  always @(posedge clk) begin
    if (rst) edges <= '0;
    else     edges <= edges + 1'b1;
  end

  ftc_capture_unit #(.LO_W(LO_W), .HI_W(HI_W), .DEPTH(DEPTH)) i_ftc_capture_unit (
    .clk(clk), .rst(rst),
    .rx_dv(rx_dv), .rx_byte(rx_byte), .tx_dv(tx_dv), .tx_byte(tx_byte),
    .ts_event(ts_event), .rd_en(rd_en), .rd_valid(rd_valid), .rd_dir(rd_dir),
    .rd_time(rd_time), .fifo_empty(fifo_empty), .overflow(overflow)
  );

  task automatic check(input bit cond, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!cond) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] frame_byte(input int idx, input int kind);
    logic [7:0] b;
    b = 8'(idx) ^ 8'h3C;
    case (idx)
      12: b = (kind == K_ETYPE) ? 8'h86 : 8'h08;
      13: b = (kind == K_ETYPE) ? 8'hDD : 8'h00;
      14: b = 8'h45;
      23: b = (kind == K_PROTO) ? 8'h06 : 8'h11;
      36: b = 8'h01;
      37: b = (kind == K_PORT) ? 8'h40 : 8'h3F;
      default: ;
    endcase
    return b;
  endfunction

  // drives frames on the chosen lanes with a shared timing; align >= 0
  // places the delimiter where the raw low part equals align
  task automatic run_frames(input bit use_rx, input int kind_rx,
                            input bit use_tx, input int kind_tx,
                            input int align, output logic [TS_W-1:0] ts);
    int len_rx, len_tx;
    len_rx = (kind_rx == K_SHORT) ? 30 : 60;
    len_tx = (kind_tx == K_SHORT) ? 30 : 60;
    ts = '0;
    @(negedge clk);
    if (align >= 0)
      while (((int'(edges) + 7) % (1 << LO_W)) != align) @(negedge clk);
    for (int p = 0; p < 7; p++) begin
      rx_dv = use_rx; rx_byte = 8'h55;
      tx_dv = use_tx; tx_byte = 8'h55;
      @(negedge clk);
    end
    ts = edges;
    rx_dv = use_rx; rx_byte = 8'hD5;
    tx_dv = use_tx; tx_byte = 8'hD5;
    @(negedge clk);
    for (int i = 0; i < 60; i++) begin
      if (i == 0) begin
        check(ts_event == {use_tx, use_rx}, "R3", "event after delimiter",
              32'(ts_event), 32'({use_tx, use_rx}));
      end
      if (i == 1) check(ts_event == 2'b00, "R3", "event single cycle",
                        32'(ts_event), 32'h0);
      rx_dv = use_rx && (i < len_rx); rx_byte = frame_byte(i, kind_rx);
      tx_dv = use_tx && (i < len_tx); tx_byte = frame_byte(i, kind_tx);
      @(negedge clk);
    end
    rx_dv = 1'b0; tx_dv = 1'b0;
    repeat (12) @(negedge clk);
  endtask

  task automatic read_expect(input bit dir, input logic [TS_W-1:0] ts, input string req);
    check(!fifo_empty, req, "entry present", 32'(fifo_empty), 32'h0);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    check(rd_valid === 1'b1, req, "read valid", 32'(rd_valid), 32'h1);
    check(rd_dir === dir, req, "direction", 32'(rd_dir), 32'(dir));
    check(rd_time === ts, req, "timestamp", 32'(rd_time), 32'(ts));
    @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(fifo_empty === 1'b1, "R8", "empty after reset", 32'(fifo_empty), 32'h1);
    check(overflow === 1'b0, "R8", "overflow after reset", 32'(overflow), 32'h0);
    check(ts_event === 2'b00, "R8", "event after reset", 32'(ts_event), 32'h0);
    check(rd_valid === 1'b0, "R8", "read valid after reset", 32'(rd_valid), 32'h0);
  endtask

  task automatic t_single();
    logic [TS_W-1:0] ts;
    run_frames(1'b1, K_PTP, 1'b0, K_PTP, -1, ts);
    read_expect(1'b0, ts, "R1 R2 R4");
    run_frames(1'b0, K_PTP, 1'b1, K_PTP, -1, ts);
    read_expect(1'b1, ts, "R2 R4 R6");
    check(fifo_empty === 1'b1, "R4", "one entry per frame", 32'(fifo_empty), 32'h1);
  endtask

  task automatic t_rejects();
    logic [TS_W-1:0] ts;
    run_frames(1'b1, K_PORT, 1'b0, K_PTP, -1, ts);
    check(fifo_empty === 1'b1, "R5", "wrong port dropped", 32'(fifo_empty), 32'h1);
    run_frames(1'b0, K_PTP, 1'b1, K_ETYPE, -1, ts);
    check(fifo_empty === 1'b1, "R5", "wrong ethertype dropped", 32'(fifo_empty), 32'h1);
    run_frames(1'b1, K_PROTO, 1'b0, K_PTP, -1, ts);
    check(fifo_empty === 1'b1, "R5", "wrong protocol dropped", 32'(fifo_empty), 32'h1);
    run_frames(1'b1, K_SHORT, 1'b1, K_SHORT, -1, ts);
    check(fifo_empty === 1'b1, "R5", "truncated dropped", 32'(fifo_empty), 32'h1);
  endtask

  task automatic t_both_lanes();
    logic [TS_W-1:0] ts;
    run_frames(1'b1, K_PTP, 1'b1, K_PTP, -1, ts);
    read_expect(1'b0, ts, "R6 rx first");
    read_expect(1'b1, ts, "R6 tx second");
  endtask

  task automatic t_wrap();
    logic [TS_W-1:0] ts0, ts1;
    run_frames(1'b1, K_PTP, 1'b0, K_PTP, 0, ts0);
    run_frames(1'b0, K_PTP, 1'b1, K_PTP, (1 << LO_W) - 1, ts1);
    check(ts0[LO_W-1:0] == '0, "R10", "low part at wrap", 32'(ts0[LO_W-1:0]), 32'h0);
    read_expect(1'b0, ts0, "R10 post-wrap high word");
    read_expect(1'b1, ts1, "R10 last before wrap");
  endtask

  task automatic t_overflow();
    logic [TS_W-1:0] exp_ts [DEPTH];
    logic [TS_W-1:0] ts;
    for (int k = 0; k < DEPTH; k++) begin
      run_frames(k[0], K_PTP, !k[0], K_PTP, -1, ts);
      exp_ts[k] = ts;
    end
    check(overflow === 1'b0, "R7", "no overflow at exactly full", 32'(overflow), 32'h0);
    run_frames(1'b1, K_PTP, 1'b0, K_PTP, -1, ts);
    check(overflow === 1'b1, "R7", "overflow on extra entry", 32'(overflow), 32'h1);
    for (int k = 0; k < DEPTH; k++) read_expect(!k[0], exp_ts[k], "R7 kept entries");
    check(fifo_empty === 1'b1, "R7", "extra entry discarded", 32'(fifo_empty), 32'h1);
    check(overflow === 1'b1, "R7", "overflow sticky", 32'(overflow), 32'h1);
  endtask

  task automatic t_empty_read();
    logic [TS_W-1:0] ts;
    @(negedge clk);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    check(rd_valid === 1'b0, "R9", "pop on empty ignored", 32'(rd_valid), 32'h0);
    run_frames(1'b1, K_PTP, 1'b0, K_PTP, -1, ts);
    read_expect(1'b0, ts, "R9 entry intact after empty pop");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_single();
    t_rejects();
    t_both_lanes();
    t_wrap();
    t_empty_read();
    t_overflow();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(20 * 150000);
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule